// File: doc/BRIEF.md
# Configurable GPIO Function Multiplexer

This block sits between eight bidirectional general-purpose pads and the rest of a clock-management chip. A 3-bit mode field for each pin chooses the pin's direction and role. An input pin can gate an output-enable bit, drive a reference clock-select bit, or feed a plain readable input bit. An output pin can carry a live status signal (loss of signal, holdover or loss of lock) or a bit driven from a register. The pad drivers, the register bus and any further input conditioning sit outside this block. Configuration arrives on parallel ports.

The mapping from pins to fixed functions is fixed and uneven. Only four pins have a clock-select role. Each output pin carries its own status signal. Until the configuration-valid input is raised, and for as long as reset is held, every pin acts as an output-enable input, whatever its mode field says. Input pads pass through a two-flop synchroniser before they reach any function output. Output pads follow their sources combinationally.

Top module: `gpio_fn_mux`

## Requirements
- R1: While `rst_n` is low, `pad_en`, `pad_o`, `clk_out_en`, `ref_sel_a`, `ref_sel_b` and `gp_in_q` are all zero, whatever the other inputs are.
- R2: While `cfg_loaded` is low, every pin is an output-enable input. `pad_en` is zero, `clk_out_en[n]` follows the synchronised `pad_i[n]`, and the clock-select and general-input outputs are zero, whatever `pin_mode_cfg` holds.
- R3: An input pad value that is stable before rising edge k reaches its function output just after rising edge k+1 (two flops). It is not visible after edge k alone.
- R4: Mode code 0 (output-enable input) makes `clk_out_en[n]` equal the synchronised pad value and keeps that pad's driver off.
- R5: Mode code 1 (clock-select input) is available only on pins 7, 6, 3 and 2. These pins drive `ref_sel_b[1]`, `ref_sel_a[1]`, `ref_sel_b[0]` and `ref_sel_a[0]` respectively, from the synchronised pad.
- R6: A clock-select bit whose pin is not in mode 1 reads 0. A clock-select bit that reads 1 always belongs to an input pin.
- R7: Mode code 2 (general input) makes `gp_in_q[n]` equal the synchronised pad. `gp_in_q[n]` is 0 for a pin in any other mode, and so is `pad_o[n]` of a pin whose driver is off.
- R8: Mode code 4 (status output) enables the driver. Pins 7 down to 0 carry `los_i[3]`, `los_i[2]`, `los_i[1]`, `holdover_i[1]`, `lol_i[1]`, `los_i[0]`, `holdover_i[0]` and `lol_i[0]`, with no register in the path.
- R9: Mode code 5 (general output) enables the driver and puts `gp_out_val[n]` on `pad_o[n]`.
- R10: Codes 3, 6 and 7 fall back to output-enable input. So does code 1 on a pin without a clock-select role (pins 5, 4, 1, 0).
- R11: `clk_out_en[n]` is 1 for every pin that is configured and not acting as an output-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_loaded | input | 1 | High once the configuration is valid |
| pin_mode_cfg | input | 24 | Mode field of pin n at bits [3n+2:3n] |
| gp_out_val | input | 8 | Register values for general-output pins |
| los_i | input | 4 | Loss-of-signal status per input reference |
| holdover_i | input | 2 | Holdover status per PLL |
| lol_i | input | 2 | Loss-of-lock status per PLL |
| pad_i | input | 8 | Pad receive values |
| pad_o | output | 8 | Pad drive values |
| pad_en | output | 8 | Pad driver enables, 1 = driving |
| clk_out_en | output | 8 | Output-enable bits taken from the pins |
| ref_sel_a | output | 2 | First clock-select pair |
| ref_sel_b | output | 2 | Second clock-select pair |
| gp_in_q | output | 8 | Synchronised general-input bits |

## Verification
The main function is tried with every pin in one mode at a time. Uniform input modes use pad patterns whose bits differ between the clock-select pins and the others, which exposes a wrong pin-to-select mapping or a missing fallback. Uniform output modes use status and register patterns with different bits set, so a swapped status line shows up. A mixed vector gives each pin a different role, including reserved codes, to catch cross-talk between neighbouring pins. Directed steps cover reset, the unconfigured state, the exact two-edge input latency and the same-cycle status path.

// File: rtl/gpio_fn_pkg.sv
`timescale 1ns/1ps
package gpio_fn_pkg;

  localparam int unsigned NUM_PINS  = 8;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned CSEL_BITS = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_OE_IN   = 3'd0,
    PM_CSEL_IN = 3'd1,
    PM_GP_IN   = 3'd2,
    PM_RSV3    = 3'd3,
    PM_STAT    = 3'd4,
    PM_GP_OUT  = 3'd5,
    PM_RSV6    = 3'd6,
    PM_RSV7    = 3'd7
  } pin_mode_e;

  // pin index that feeds clock-select slot k; slot order {b[1],b[0],a[1],a[0]}
  function automatic int unsigned slot_pin(int unsigned k);
    case (k)
      0:       return 2;
      1:       return 6;
      2:       return 3;
      default: return 7;
    endcase
  endfunction

  function automatic logic pin_has_csel(int unsigned p);
    return (p == 2) || (p == 3) || (p == 6) || (p == 7);
  endfunction

  // effective mode after validity, reserved codes and pin capability
  function automatic pin_mode_e resolve_mode(logic [MODE_W-1:0] raw,
                                             logic has_csel, logic cfg_ok);
    pin_mode_e m;
    if (!cfg_ok) return PM_OE_IN;
    m = pin_mode_e'(raw);
    case (m)
      PM_OE_IN, PM_GP_IN, PM_STAT, PM_GP_OUT: return m;
      PM_CSEL_IN: return has_csel ? PM_CSEL_IN : PM_OE_IN;
      default:    return PM_OE_IN;
    endcase
  endfunction

  // live status lines arranged by pin, index 7 down to 0
  function automatic logic [NUM_PINS-1:0] status_route(logic [3:0] los,
                                                       logic [1:0] hold,
                                                       logic [1:0] lol);
    return {los[3], los[2], los[1], hold[1], lol[1], los[0], hold[0], lol[0]};
  endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
`timescale 1ns/1ps
module gpio_sync_chain #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic             warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      warm_q <= 1'b0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      warm_q <= 1'b1;
    end
  end

  assign q = stage_q[STAGES-1];

  // R3
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> (q == $past(stage_q[STAGES-2])));

endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell
  import gpio_fn_pkg::*;
#(
  parameter bit HAS_CSEL = 1'b0
) (
  input  logic [MODE_W-1:0] raw_mode,
  input  logic              cfg_ok,
  input  logic              sync_in,
  input  logic              stat_in,
  input  logic              gpo_in,
  output logic              pad_out,
  output logic              pad_drv,
  output logic              oe_bit,
  output logic              csel_bit,
  output logic              gpi_bit
);

  pin_mode_e mode_eff;
  assign mode_eff = resolve_mode(raw_mode, HAS_CSEL, cfg_ok);

  always_comb begin
    pad_out  = 1'b0;
    pad_drv  = 1'b0;
    oe_bit   = 1'b1;
    csel_bit = 1'b0;
    gpi_bit  = 1'b0;
    case (mode_eff)
      PM_CSEL_IN: csel_bit = sync_in;
      PM_GP_IN:   gpi_bit  = sync_in;
      PM_STAT: begin
        pad_drv = 1'b1;
        pad_out = stat_in;
      end
      PM_GP_OUT: begin
        pad_drv = 1'b1;
        pad_out = gpo_in;
      end
      default:    oe_bit = sync_in;
    endcase
  end

endmodule

// File: rtl/gpio_fn_mux.sv
`timescale 1ns/1ps
module gpio_fn_mux
  import gpio_fn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_loaded,
  input  logic [NUM_PINS*MODE_W-1:0] pin_mode_cfg,
  input  logic [NUM_PINS-1:0]        gp_out_val,
  input  logic [3:0]                 los_i,
  input  logic [1:0]                 holdover_i,
  input  logic [1:0]                 lol_i,
  input  logic [NUM_PINS-1:0]        pad_i,
  output logic [NUM_PINS-1:0]        pad_o,
  output logic [NUM_PINS-1:0]        pad_en,
  output logic [NUM_PINS-1:0]        clk_out_en,
  output logic [1:0]                 ref_sel_a,
  output logic [1:0]                 ref_sel_b,
  output logic [NUM_PINS-1:0]        gp_in_q
);

  localparam int unsigned HALF_SEL = CSEL_BITS / 2;

  logic                 cfg_ok;
  logic [NUM_PINS-1:0]  pad_sync;
  logic [NUM_PINS-1:0]  stat_by_pin;
  logic [NUM_PINS-1:0]  csel_w;
  logic [CSEL_BITS-1:0] csel_vec;

  // reset forces the unconfigured behaviour
  assign cfg_ok      = cfg_loaded & rst_n;
  assign stat_by_pin = status_route(los_i, holdover_i, lol_i);

  gpio_sync_chain #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_i),
    .q    (pad_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell #(.HAS_CSEL(pin_has_csel(p))) u_cell (
      .raw_mode(pin_mode_cfg[p*MODE_W +: MODE_W]),
      .cfg_ok  (cfg_ok),
      .sync_in (pad_sync[p]),
      .stat_in (stat_by_pin[p]),
      .gpo_in  (gp_out_val[p]),
      .pad_out (pad_o[p]),
      .pad_drv (pad_en[p]),
      .oe_bit  (clk_out_en[p]),
      .csel_bit(csel_w[p]),
      .gpi_bit (gp_in_q[p])
    );

    // R11
    oe_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_en[p] |-> clk_out_en[p]);

    // R7
    pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_en[p] |-> !pad_o[p]);

    if (!pin_has_csel(p)) begin : g_nocsel
      // R10
      nocsel_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csel_w[p]);
    end
  end

  for (genvar k = 0; k < CSEL_BITS; k++) begin : g_csel
    assign csel_vec[k] = csel_w[slot_pin(k)];

    // R6
    csel_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csel_vec[k] |-> !pad_en[slot_pin(k)]);
  end

  assign ref_sel_a = csel_vec[HALF_SEL-1:0];
  assign ref_sel_b = csel_vec[CSEL_BITS-1:HALF_SEL];

  // R2
  cfg_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_loaded |-> (pad_en == '0 && csel_vec == '0 && gp_in_q == '0));

endmodule

// File: tb/gpio_fn_mux_test.sv
`timescale 1ns/1ps
module gpio_fn_mux_test;

  localparam logic [2:0] M_OE = 3'd0, M_CS = 3'd1, M_GI = 3'd2, M_R3 = 3'd3,
                         M_ST = 3'd4, M_GO = 3'd5, M_R7 = 3'd7;

  typedef struct packed {
    logic [23:0] mode;   // pin 7 field first
    logic [7:0]  pin;
    logic [7:0]  gpo;
    logic [7:0]  stat;   // per-pin status order, pin 7 first
    logic [7:0]  x_en;
    logic [7:0]  x_out;
    logic [7:0]  x_oe;
    logic [3:0]  x_sel;  // {ref_sel_b, ref_sel_a}
    logic [7:0]  x_gpi;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{ {8{M_OE}}, 8'hA5, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hA5, 4'h0, 8'h00 },
    '{ {8{M_CS}}, 8'hCC, 8'h00, 8'h00, 8'h00, 8'h00, 8'hCC, 4'hF, 8'h00 },
    '{ {8{M_CS}}, 8'h84, 8'h00, 8'h00, 8'h00, 8'h00, 8'hCC, 4'h9, 8'h00 },
    '{ {8{M_GI}}, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 4'h0, 8'h5A },
    '{ {8{M_ST}}, 8'hFF, 8'h00, 8'h96, 8'hFF, 8'h96, 8'hFF, 4'h0, 8'h00 },
    '{ {8{M_ST}}, 8'h00, 8'hFF, 8'h69, 8'hFF, 8'h69, 8'hFF, 4'h0, 8'h00 },
    '{ {8{M_GO}}, 8'hFF, 8'h3C, 8'hFF, 8'hFF, 8'h3C, 8'hFF, 4'h0, 8'h00 },
    '{ {M_CS, M_GI, M_ST, M_GO, M_R3, M_OE, M_R7, M_GI},
       8'h81, 8'hEF, 8'hFF, 8'h30, 8'h20, 8'hF1, 4'h8, 8'h01 },
    '{ {M_GO, M_GO, M_CS, M_GO, M_GO, M_GO, M_GO, M_GO},
       8'h00, 8'h00, 8'h00, 8'hDF, 8'h00, 8'hDF, 4'h0, 8'h00 }
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_loaded;
  logic [23:0] pin_mode_cfg;
  logic [7:0]  gp_out_val;
  logic [3:0]  los_i;
  logic [1:0]  holdover_i;
  logic [1:0]  lol_i;
  logic [7:0]  pad_i;
  logic [7:0]  pad_o, pad_en, clk_out_en, gp_in_q;
  logic [1:0]  ref_sel_a, ref_sel_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_fn_mux uut (
    .clk(clk), .rst_n(rst_n), .cfg_loaded(cfg_loaded),
    .pin_mode_cfg(pin_mode_cfg), .gp_out_val(gp_out_val),
    .los_i(los_i), .holdover_i(holdover_i), .lol_i(lol_i),
    .pad_i(pad_i), .pad_o(pad_o), .pad_en(pad_en),
    .clk_out_en(clk_out_en), .ref_sel_a(ref_sel_a),
    .ref_sel_b(ref_sel_b), .gp_in_q(gp_in_q)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_stat(logic [7:0] s);
    los_i      = {s[7], s[6], s[5], s[2]};
    holdover_i = {s[4], s[1]};
    lol_i      = {s[3], s[0]};
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_loaded = 1'b1; pin_mode_cfg = {8{M_GO}};
    gp_out_val = 8'hFF; set_stat(8'hFF); pad_i = 8'hFF;
    settle();
    // R1 reset state
    chk("R1 pad_en",     pad_en, 0);
    chk("R1 pad_o",      pad_o, 0);
    chk("R1 clk_out_en", clk_out_en, 0);
    chk("R1 ref_sel",    {ref_sel_b, ref_sel_a}, 0);
    chk("R1 gp_in_q",    gp_in_q, 0);
    rst_n = 1'b1;

    // vector table: R4 R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      pin_mode_cfg = VEC[v].mode; pad_i = VEC[v].pin;
      gp_out_val = VEC[v].gpo; set_stat(VEC[v].stat);
      settle();
      chk($sformatf("R8/R9 v%0d pad_en", v),     pad_en, VEC[v].x_en);
      chk($sformatf("R8/R9 v%0d pad_o", v),      pad_o, VEC[v].x_out);
      chk($sformatf("R4/R11 v%0d clk_out_en", v), clk_out_en, VEC[v].x_oe);
      chk($sformatf("R5/R6/R10 v%0d ref_sel", v), {ref_sel_b, ref_sel_a}, VEC[v].x_sel);
      chk($sformatf("R7 v%0d gp_in_q", v),       gp_in_q, VEC[v].x_gpi);
    end

    // R2 unconfigured: modes ignored
    cfg_loaded = 1'b0; pin_mode_cfg = {M_CS, M_GI, M_ST, M_GO, M_CS, M_CS, M_GI, M_GO};
    pad_i = 8'h3C; gp_out_val = 8'hFF; set_stat(8'hFF);
    settle();
    chk("R2 pad_en",     pad_en, 0);
    chk("R2 clk_out_en", clk_out_en, 8'h3C);
    chk("R2 ref_sel",    {ref_sel_b, ref_sel_a}, 0);
    chk("R2 gp_in_q",    gp_in_q, 0);

    // R3 two-edge latency
    pad_i = 8'h00; settle();
    pad_i = 8'hE7;
    @(posedge clk); @(negedge clk);
    chk("R3 after one edge",  clk_out_en, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R3 after two edges", clk_out_en, 8'hE7);

    // R8 status path without any clock edge
    cfg_loaded = 1'b1; pin_mode_cfg = {8{M_ST}}; set_stat(8'h00);
    settle();
    set_stat(8'h5B); #1;
    chk("R8 same-cycle status", pad_o, 8'h5B);
    set_stat(8'hA4); #1;
    chk("R8 status released",   pad_o, 8'hA4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule